// File: doc/BRIEF.md
# Packed Half-Precision Lane Converter

This block converts between 16-bit half-precision and 32-bit single-precision floating-point values held in packed register words. One half-to-single converter and one single-to-half converter are shared by every operation. A scalar operation converts either the low or the high 16-bit half of a word. When a scalar narrowing result is written back, only the chosen half of the destination changes. A vector operation turns four single-precision lanes into two words of packed halves, or two packed words into four single-precision lanes. It moves one lane per cycle through the shared converter.

Each operation starts with a one-cycle `start` pulse while the unit is idle. Operands are captured at that edge. A feature-enable input gates every operation, and an unknown opcode is refused. A format select, driven from bit 26 of the floating-point control word, picks the half-precision encoding. With the bit at 0 the encoding is IEEE 754 binary16. With the bit at 1 it is an alternative encoding that has no infinity or NaN, so exponent code 31 is an ordinary binade. Narrowing always rounds to nearest, ties to even. Exception flags from all lanes are ORed together and reported with `done`.

Top module: `hcvt_lane_unit`

## Requirements
- R1: With `fmt_alt`=0, half exponent code 31 means infinity or NaN. With `fmt_alt`=1, it is a normal binade. Widening 0x7C00 gives 0x7F800000 in IEEE mode and 0x47800000 in alternative mode. Narrowing overflows above unbiased exponent 15 in IEEE mode and above 16 in alternative mode.
- R2: Opcode 0 (widen low) converts `src[15:0]` into `res[31:0]`, with all other `res` bits zero. `done` is high in the second cycle after the accepting edge.
- R3: Opcode 1 (widen high) converts `src[31:16]` into `res[31:0]`, with the same timing as R2.
- R4: Opcode 2 (narrow low) converts `src[31:0]`. It gives `res[31:0]` = {`dst_old[31:16]`, result}, with the upper `res` bits zero.
- R5: Opcode 3 (narrow high) converts `src[31:0]`. It gives `res[31:0]` = {result, `dst_old[15:0]`}.
- R6: Opcode 4 (vector narrow) narrows lane k = `src[32k+31:32k]`. Lane 0 goes to `res[15:0]`, lane 1 to `res[31:16]`, lane 2 to `res[47:32]` and lane 3 to `res[63:48]`. `done` is high in the fifth cycle after the accepting edge.
- R7: Opcode 5 (vector widen) widens `src[16k+15:16k]` into `res[32k+31:32k]` for k = 0..3. It has the R6 timing.
- R8: If `start` arrives while idle with `fp16_en`=0 or with opcode 6 or 7, `undef` pulses for one cycle. In that case `done` and `busy` stay low, and `res` and `flags` keep their values.
- R9: `start` is ignored while `busy` is high. The running operation finishes with its own operands and timing, and no extra `done` follows.
- R10: `flags` = {invalid, overflow, underflow, inexact}, bits 3 down to 0. They are cleared when an operation is accepted, ORed over all of its lanes, and valid while `done` is high.
- R11: Narrowing rounds to nearest with ties to even. A normal result that exceeds the format range becomes infinity in IEEE mode or 0x7FFF/0xFFFF in alternative mode, and raises overflow and inexact.
- R12: A narrowing result below 2^-14 is rounded to a subnormal, possibly reaching 0x0400. Underflow and inexact are raised when bits are lost. A single-precision subnormal input narrows to signed zero. Half subnormals widen exactly.
- R13: In IEEE mode, NaNs are returned quiet with the payload kept, and a signalling NaN raises invalid. In alternative mode, narrowing turns a NaN into signed zero and an infinity into signed 0x7FFF, both raising invalid.
- R14: After reset, `busy`, `done`, `undef`, `res` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request, sampled while idle |
| op | input | 3 | Opcode 0..5, see R2 to R7 |
| fp16_en | input | 1 | Half-precision feature enable |
| fmt_alt | input | 1 | Bit 26 of the control word: 0 IEEE, 1 alternative format |
| src | input | 128 | Source lanes or packed source words |
| dst_old | input | 32 | Current destination word, merged by scalar narrowing |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse, with `res` and `flags` valid |
| undef | output | 1 | One-cycle rejection pulse |
| res | output | 128 | Result lanes or packed result words |
| flags | output | 4 | Accumulated exception flags |

## Verification
A scalar result is due in the second cycle after the edge that accepts `start`, a four-lane result in the fifth, and a rejection pulse in the first. The bench drives each request just after a falling edge. It then counts falling edges. It checks that `done` is low on every edge before the due one, and only on the due edge does it compare `res` and `flags`. For the ignored-start and rejection cases, it samples `done`, `busy` and `res` on each edge of the window and for a few edges after it.

// File: rtl/hcvt_pkg.sv
`timescale 1ns/1ps
package hcvt_pkg;
    typedef enum logic [2:0] {
        OP_WIDEN_LO   = 3'd0,
        OP_WIDEN_HI   = 3'd1,
        OP_NARROW_LO  = 3'd2,
        OP_NARROW_HI  = 3'd3,
        OP_VEC_NARROW = 3'd4,
        OP_VEC_WIDEN  = 3'd5
    } op_e;

    localparam int FLG_W   = 4;
    localparam int FLG_INV = 3;
    localparam int FLG_OVF = 2;
    localparam int FLG_UNF = 1;
    localparam int FLG_INX = 0;
endpackage

// File: rtl/hcvt_widen.sv
`timescale 1ns/1ps
module hcvt_widen
    import hcvt_pkg::*;
(
    input  logic [15:0]      half_i,
    input  logic             alt_i,
    output logic [31:0]      sgl_o,
    output logic [FLG_W-1:0] flg_o
);
    logic       sgn;
    logic [4:0] ex;
    logic [9:0] mt;
    logic [3:0] lead;

    assign sgn = half_i[15];
    assign ex  = half_i[14:10];
    assign mt  = half_i[9:0];

    always_comb begin
        lead = 4'd0;
        for (int i = 0; i < 10; i++) begin
            if (mt[i]) lead = 4'(i);
        end
    end

    always_comb begin
        flg_o = '0;
        sgl_o = {sgn, 31'b0};
        if (ex == 5'h1f && !alt_i) begin
            if (mt != 10'd0) begin
                // quiet the NaN, keep payload
                sgl_o = {sgn, 8'hff, 1'b1, mt[8:0], 13'b0};
                flg_o[FLG_INV] = !mt[9];
            end else begin
                sgl_o = {sgn, 8'hff, 23'b0};
            end
        end else if (ex == 5'd0) begin
            if (mt != 10'd0) begin
                // subnormal half: renormalise, value = mt * 2^-24
                sgl_o = {sgn, 8'(lead) + 8'd103, 10'(mt << (4'd10 - lead)), 13'b0};
            end
        end else begin
            sgl_o = {sgn, {3'b000, ex} + 8'd112, mt, 13'b0};
        end
    end
endmodule

// File: rtl/hcvt_narrow.sv
`timescale 1ns/1ps
module hcvt_narrow
    import hcvt_pkg::*;
(
    input  logic [31:0]      sgl_i,
    input  logic             alt_i,
    output logic [15:0]      half_o,
    output logic [FLG_W-1:0] flg_o
);
    logic               sgn;
    logic [7:0]         ex;
    logic [22:0]        mt;
    logic signed [9:0]  e_unb;
    logic signed [9:0]  e_rnd;
    logic signed [9:0]  neg_sh;
    logic signed [9:0]  e_lim;
    logic [4:0]         sh;
    logic               rup_n;
    logic               carry_n;
    logic [9:0]         frac_n;
    logic [47:0]        sub_x;
    logic               rup_s;

    assign sgn   = sgl_i[31];
    assign ex    = sgl_i[30:23];
    assign mt    = sgl_i[22:0];
    assign e_unb = $signed({2'b00, ex}) - 10'sd127;
    assign e_lim = alt_i ? 10'sd16 : 10'sd15;

    // normal-range path: keep 10 fraction bits, round on the low 13
    assign rup_n   = mt[12] && ((mt[11:0] != 12'd0) || mt[13]);
    assign frac_n  = mt[22:13] + 10'(rup_n);
    assign carry_n = (&mt[22:13]) && rup_n;
    assign e_rnd   = e_unb + (carry_n ? 10'sd1 : 10'sd0);

    // subnormal path: value / 2^-24 = m24 >> -(e+1), clamped at 25
    assign neg_sh = -(e_unb + 10'sd1);
    assign sh     = (neg_sh > 10'sd25) ? 5'd25 : neg_sh[4:0];
    assign sub_x  = {1'b1, mt, 24'b0} >> sh;
    assign rup_s  = sub_x[23] && ((sub_x[22:0] != 23'd0) || sub_x[24]);

    always_comb begin
        flg_o  = '0;
        half_o = {sgn, 15'b0};
        if (ex == 8'hff) begin
            if (alt_i) begin
                flg_o[FLG_INV] = 1'b1;
                half_o = (mt != 23'd0) ? {sgn, 15'b0} : {sgn, 15'h7fff};
            end else if (mt != 23'd0) begin
                half_o = {sgn, 5'h1f, 1'b1, mt[21:13]};
                flg_o[FLG_INV] = !mt[22];
            end else begin
                half_o = {sgn, 5'h1f, 10'b0};
            end
        end else if (ex == 8'd0) begin
            if (mt != 23'd0) begin
                flg_o[FLG_UNF] = 1'b1;
                flg_o[FLG_INX] = 1'b1;
            end
        end else if (e_unb < -10'sd14) begin
            half_o = {sgn, 15'(sub_x[47:24] + 24'(rup_s))};
            if (sub_x[23:0] != 24'd0) begin
                flg_o[FLG_UNF] = 1'b1;
                flg_o[FLG_INX] = 1'b1;
            end
        end else if (e_rnd > e_lim) begin
            half_o = alt_i ? {sgn, 15'h7fff} : {sgn, 5'h1f, 10'b0};
            flg_o[FLG_OVF] = 1'b1;
            flg_o[FLG_INX] = 1'b1;
        end else begin
            half_o = {sgn, 5'(e_rnd + 10'sd15), frac_n};
            flg_o[FLG_INX] = (mt[12:0] != 13'd0);
        end
    end
endmodule

// File: rtl/hcvt_lane_unit.sv
`timescale 1ns/1ps
module hcvt_lane_unit
    import hcvt_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [2:0]             op,
    input  logic                   fp16_en,
    input  logic                   fmt_alt,
    input  logic [LANES*32-1:0]    src,
    input  logic [31:0]            dst_old,
    output logic                   busy,
    output logic                   done,
    output logic                   undef,
    output logic [LANES*32-1:0]    res,
    output logic [FLG_W-1:0]       flags
);
    localparam int SW    = 32;
    localparam int HW    = 16;
    localparam int SRC_W = LANES * SW;
    localparam int LW    = (LANES > 2) ? $clog2(LANES) : 1;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             undef;
        logic [2:0]       op;
        logic             alt;
        logic [LW-1:0]    lane;
        logic [LW-1:0]    last;
        logic [SRC_W-1:0] src;
        logic [SRC_W-1:0] res;
        logic [FLG_W-1:0] flg;
    } state_t;

    state_t st_d, st_q;

    logic [HW-1:0]    w_in;
    logic [SW-1:0]    w_out;
    logic [FLG_W-1:0] w_flg;
    logic [SW-1:0]    n_in;
    logic [HW-1:0]    n_out;
    logic [FLG_W-1:0] n_flg;

    assign w_in = st_q.src[HW*int'(st_q.lane) +: HW];
    assign n_in = st_q.src[SW*int'(st_q.lane) +: SW];

    hcvt_widen u_widen (
        .half_i (w_in),
        .alt_i  (st_q.alt),
        .sgl_o  (w_out),
        .flg_o  (w_flg)
    );

    hcvt_narrow u_narrow (
        .sgl_i  (n_in),
        .alt_i  (st_q.alt),
        .half_o (n_out),
        .flg_o  (n_flg)
    );

    logic          legal_op;
    logic          in_vec;
    logic          in_narrow;
    logic          cur_narrow;
    logic          cur_vec;
    logic [LW-1:0] slot;

    always_comb begin
        legal_op   = (op <= 3'd5);
        in_vec     = (op == OP_VEC_NARROW) || (op == OP_VEC_WIDEN);
        in_narrow  = (op == OP_NARROW_LO) || (op == OP_NARROW_HI);
        cur_narrow = (st_q.op == OP_NARROW_LO) || (st_q.op == OP_NARROW_HI)
                   || (st_q.op == OP_VEC_NARROW);
        cur_vec    = (st_q.op == OP_VEC_NARROW) || (st_q.op == OP_VEC_WIDEN);
        if (st_q.op == OP_NARROW_HI) begin
            slot = LW'(1);
        end else if (cur_vec) begin
            slot = st_q.lane;
        end else begin
            slot = '0;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.undef = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                if (!fp16_en || !legal_op) begin
                    st_d.undef = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                    st_d.op   = op;
                    st_d.alt  = fmt_alt;
                    st_d.src  = src;
                    st_d.flg  = '0;
                    st_d.res  = in_narrow ? {{(SRC_W-SW){1'b0}}, dst_old} : '0;
                    st_d.lane = (op == OP_WIDEN_HI) ? LW'(1) : '0;
                    if (in_vec) begin
                        st_d.last = LW'(LANES - 1);
                    end else begin
                        st_d.last = (op == OP_WIDEN_HI) ? LW'(1) : '0;
                    end
                end
            end
        end else begin
            if (cur_narrow) begin
                st_d.res[HW*int'(slot) +: HW] = n_out;
                st_d.flg = st_q.flg | n_flg;
            end else begin
                st_d.res[SW*int'(slot) +: SW] = w_out;
                st_d.flg = st_q.flg | w_flg;
            end
            if (st_q.lane == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.lane = st_q.lane + LW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = st_q.busy;
    assign done  = st_q.done;
    assign undef = st_q.undef;
    assign res   = st_q.res;
    assign flags = st_q.flg;
endmodule

// File: rtl/hcvt_lane_unit_chk.sv
`timescale 1ns/1ps
module hcvt_lane_unit_chk #(
    parameter int LANES = 4,
    parameter int SRC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [2:0]       op,
    input logic             fp16_en,
    input logic [31:0]      dst_old,
    input logic             busy,
    input logic             done,
    input logic             undef,
    input logic [SRC_W-1:0] res,
    input logic [3:0]       flags
);
    localparam int CW = $clog2(LANES) + 1;

    logic          ok_req;
    logic          take;
    logic          refuse;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] exp_q;

    assign ok_req = fp16_en && (op <= 3'd5);
    assign take   = start && !busy && ok_req;
    assign refuse = start && !busy && !ok_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= '0;
        end else if (take) begin
            cnt_q <= '0;
            exp_q <= (op == 3'd4 || op == 3'd5) ? CW'(LANES) : CW'(1);
        end else if (busy) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    a_r8_undef_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        refuse |=> (undef && !busy && !done));
    a_r8_undef_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        refuse |=> ($stable(res) && $stable(flags)));
    a_r9_done_undef_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, undef}));
    a_r9_done_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r2_scalar_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op <= 3'd3) |=> busy ##1 (done && !busy));
    a_r6_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q == exp_q));
    a_r4_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == 3'd2) |=> ##1 (res[31:16] == $past(dst_old[31:16], 2)));
    a_r5_keep_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == 3'd3) |=> ##1 (res[15:0] == $past(dst_old[15:0], 2)));
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy) && !$past(start)) |-> ($stable(res) && $stable(flags)));
endmodule

bind hcvt_lane_unit hcvt_lane_unit_chk #(.LANES(LANES), .SRC_W(SRC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .fp16_en (fp16_en),
    .dst_old (dst_old),
    .busy    (busy),
    .done    (done),
    .undef   (undef),
    .res     (res),
    .flags   (flags)
);

// File: tb/test_hcvt_lane_unit.sv
`timescale 1ns/1ps
module test_hcvt_lane_unit;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [2:0]   op;
    logic         fp16_en;
    logic         fmt_alt;
    logic [127:0] src;
    logic [31:0]  dst_old;
    logic         busy;
    logic         done;
    logic         undef;
    logic [127:0] res;
    logic [3:0]   flags;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    hcvt_lane_unit i_hcvt_lane_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .fp16_en(fp16_en),
        .fmt_alt(fmt_alt), .src(src), .dst_old(dst_old), .busy(busy),
        .done(done), .undef(undef), .res(res), .flags(flags)
    );

    typedef struct packed {
        logic [23:0]  tag;
        logic [2:0]   op;
        logic         alt;
        logic [127:0] src;
        logic [31:0]  old;
        logic [127:0] res;
        logic [3:0]   flg;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        '{"R2 ", 3'd0, 1'b0, 128'hABCD3C00, 32'h0, 128'h3F800000, 4'h0},
        '{"R3 ", 3'd1, 1'b0, 128'hC0001234, 32'h0, 128'hC0000000, 4'h0},
        '{"R1 ", 3'd0, 1'b0, 128'h7C00, 32'h0, 128'h7F800000, 4'h0},
        '{"R1 ", 3'd0, 1'b1, 128'h7C00, 32'h0, 128'h47800000, 4'h0},
        '{"R1 ", 3'd0, 1'b1, 128'h7FFF, 32'h0, 128'h47FFE000, 4'h0},
        '{"R13", 3'd0, 1'b0, 128'h7D00, 32'h0, 128'h7FE00000, 4'h8},
        '{"R13", 3'd0, 1'b0, 128'h7E00, 32'h0, 128'h7FC00000, 4'h0},
        '{"R12", 3'd0, 1'b0, 128'h0001, 32'h0, 128'h33800000, 4'h0},
        '{"R12", 3'd1, 1'b0, 128'h02000000, 32'h0, 128'h38000000, 4'h0},
        '{"R4 ", 3'd2, 1'b0, 128'h3F800000, 32'hDEADBEEF, 128'hDEAD3C00, 4'h0},
        '{"R5 ", 3'd3, 1'b0, 128'h3F800000, 32'hDEADBEEF, 128'h3C00BEEF, 4'h0},
        '{"R11", 3'd2, 1'b0, 128'h3F801000, 32'h0, 128'h3C00, 4'h1},
        '{"R11", 3'd2, 1'b0, 128'h3F803000, 32'h0, 128'h3C02, 4'h1},
        '{"R11", 3'd2, 1'b0, 128'h3F801001, 32'h0, 128'h3C01, 4'h1},
        '{"R11", 3'd2, 1'b0, 128'h477FF000, 32'h0, 128'h7C00, 4'h5},
        '{"R1 ", 3'd2, 1'b1, 128'h477FF000, 32'h0, 128'h7C00, 4'h1},
        '{"R11", 3'd2, 1'b0, 128'h47800000, 32'h0, 128'h7C00, 4'h5},
        '{"R1 ", 3'd2, 1'b1, 128'h47800000, 32'h0, 128'h7C00, 4'h0},
        '{"R1 ", 3'd2, 1'b1, 128'h48000000, 32'h0, 128'h7FFF, 4'h5},
        '{"R13", 3'd2, 1'b0, 128'hFF800000, 32'h0, 128'hFC00, 4'h0},
        '{"R13", 3'd2, 1'b0, 128'h7F800001, 32'h0, 128'h7E00, 4'h8},
        '{"R13", 3'd2, 1'b1, 128'h7FC00000, 32'h0, 128'h0000, 4'h8},
        '{"R13", 3'd2, 1'b1, 128'hFF800000, 32'h0, 128'hFFFF, 4'h8},
        '{"R12", 3'd2, 1'b0, 128'h33000000, 32'h0, 128'h0000, 4'h3},
        '{"R12", 3'd2, 1'b0, 128'h33000001, 32'h0, 128'h0001, 4'h3},
        '{"R12", 3'd2, 1'b0, 128'hB3800000, 32'h0, 128'h8001, 4'h0},
        '{"R12", 3'd2, 1'b0, 128'h387FF000, 32'h0, 128'h0400, 4'h3},
        '{"R12", 3'd2, 1'b0, 128'h00000001, 32'h0, 128'h0000, 4'h3},
        '{"R12", 3'd2, 1'b0, 128'h80000000, 32'h0, 128'h8000, 4'h0},
        '{"R6 ", 3'd4, 1'b0, 128'h47800000_3F000000_C0000000_3F800000, 32'h0,
          128'h7C003800_C0003C00, 4'h5},
        '{"R6 ", 3'd4, 1'b1, 128'h47800000_3F000000_C0000000_3F800000, 32'h0,
          128'h7C003800_C0003C00, 4'h0},
        '{"R10", 3'd4, 1'b0, 128'h477FF000_33000000_3F801000_7F800001, 32'h0,
          128'h7C000000_3C007E00, 4'hF},
        '{"R7 ", 3'd5, 1'b0, 128'h7D00C000_3C000001, 32'h0,
          128'h7FE00000_C0000000_3F800000_33800000, 4'h8}
    };

    task automatic check(input logic [23:0] tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input vec_t v);
        int lat;
        lat     = (v.op == 3'd4 || v.op == 3'd5) ? 5 : 2;
        start   = 1'b1;
        op      = v.op;
        fp16_en = 1'b1;
        fmt_alt = v.alt;
        src     = v.src;
        dst_old = v.old;
        for (int i = 1; i <= lat; i++) begin
            @(negedge clk);
            if (i == 1) start = 1'b0;
            if (i < lat) check(v.tag, {127'b0, done}, 128'd0);
        end
        check(v.tag, {127'b0, done}, 128'd1);
        check(v.tag, res, v.res);
        check(v.tag, {124'b0, flags}, {124'b0, v.flg});
    endtask

    task automatic refuse(input logic en, input logic [2:0] o);
        logic [127:0] prev_res;
        logic [3:0]   prev_flg;
        prev_res = res;
        prev_flg = flags;
        start    = 1'b1;
        op       = o;
        fp16_en  = en;
        src      = 128'h3F800000;
        dst_old  = 32'hFFFFFFFF;
        @(negedge clk);
        start = 1'b0;
        check("R8", {125'b0, undef, done, busy}, 128'h4);
        check("R8", res, prev_res);
        check("R8", {124'b0, flags}, {124'b0, prev_flg});
        @(negedge clk);
        check("R8", {125'b0, undef, done, busy}, 128'h0);
        check("R8", res, prev_res);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, run hung (R9)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        start   = 1'b0;
        op      = 3'd0;
        fp16_en = 1'b1;
        fmt_alt = 1'b0;
        src     = '0;
        dst_old = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14: reset state
        check("R14", {125'b0, busy, done, undef}, 128'h0);
        check("R14", res, 128'h0);
        check("R14", {124'b0, flags}, 128'h0);

        for (int k = 0; k < NV; k++) run(VECS[k]);

        // R8: feature disabled, then illegal opcode
        refuse(1'b0, 3'd2);
        refuse(1'b1, 3'd6);
        refuse(1'b1, 3'd7);

        // R9: start held while busy with other operands
        start   = 1'b1;
        op      = 3'd4;
        fp16_en = 1'b1;
        fmt_alt = 1'b0;
        src     = 128'h47800000_3F000000_C0000000_3F800000;
        dst_old = 32'h0;
        @(negedge clk);
        op  = 3'd0;
        src = 128'h0000_3C00;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check("R9", {126'b0, done, busy}, 128'h1);
        @(negedge clk);
        check("R9", {126'b0, done, busy}, 128'h2);
        check("R9", res, 128'h7C003800_C0003C00);
        check("R9", {124'b0, flags}, 128'h5);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check("R9", {126'b0, done, busy}, 128'h0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule